// File: doc/BRIEF.md
# Radar Range-Frame SPI Receiver

This block receives range-FFT frames that a radar transceiver pushes out over SPI, with the transceiver as master and this block as slave. The serial clock, data and active-low select are brought into the system clock domain through synchroniser chains. Data is taken MSB first on each rising serial-clock edge. The system clock must run at least four times faster than the serial clock, so a 10 MHz serial stream needs a system clock of 40 MHz or more. The block gathers 32-bit words and checks the opening word of each select window for a valid range-frame header. It then sends out the complex bins one at a time and checks the closing word.

A frame has 18 words: a header, 16 payload bins and a trailer. At the end of the trailer the block gives one pulse. `frame_done` marks a good frame and `frame_error` marks a broken one. The header values and the trailer values are held on output ports for the rest of the system to read. The checksum is passed through and is not checked.

Top module: `radar_frame_rx`

## Requirements
- R1: After reset, `bin_valid`, `frame_done` and `frame_error` are low, and every held field and bin output is zero.
- R2: While `spi_csn` is low, one bit of `spi_mosi` is taken on each rising edge of `spi_sclk`. The bits are taken MSB first, and every 32 edges make one word.
- R3: The first word of a select window is a valid header when bits [31:24] are 0xAA and bits [23:20] are 4'b0011. When it is valid, `chirp_idx` takes bits [19:11] and `txmax_cfg` takes bits [9:0]. Bit 10 is ignored.
- R4: If the first word has a different preamble or type, the block produces no bins and no pulses. It leaves all held fields unchanged and ignores the rest of the window until `spi_csn` goes high.
- R5: Each of the next 16 words gives one `bin_valid` pulse. `bin_idx` counts 0 to 15 in arrival order. `bin_i` is bits [31:16] and `bin_q` is bits [15:0], both signed.
- R6: The 18th word is the trailer. Its bits are: checksum [31:16], frame number [15:12], unused [11:10], config message [9:8] and postamble [7:0]. A postamble of 0x55 gives a one-cycle `frame_done` pulse and latches `checksum`, `frame_num` and `cfg_msg`.
- R7: A trailer with a postamble other than 0x55 gives a one-cycle `frame_error` pulse and no `frame_done`. The trailer fields keep their old values.
- R8: If `spi_csn` goes high after a valid header but before the trailer arrives, the block gives a one-cycle `frame_error` pulse.
- R9: Raising `spi_csn` throws away any partly shifted word, so the next window starts on a fresh word boundary.
- R10: The header fields change only on a valid header, and the trailer fields change only on a good trailer.
- R11: The checksum is not verified. Any checksum value with a 0x55 postamble gives `frame_done`, and the value appears unchanged on `checksum`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the radar |
| spi_mosi | input | 1 | Serial data from the radar |
| spi_csn | input | 1 | Active-low frame select from the radar |
| bin_valid | output | 1 | One-cycle strobe for each payload bin |
| bin_idx | output | 4 | Index of the current bin |
| bin_i | output | 16 | Signed real part of the bin |
| bin_q | output | 16 | Signed imaginary part of the bin |
| frame_done | output | 1 | Pulse for a complete frame with a good trailer |
| frame_error | output | 1 | Pulse for a bad trailer or a window cut short |
| chirp_idx | output | 9 | Chirp index from the last valid header |
| txmax_cfg | output | 10 | TX-max configuration from the last valid header |
| frame_num | output | 4 | Frame number from the last good trailer |
| cfg_msg | output | 2 | Config-message field from the last good trailer |
| checksum | output | 16 | Checksum from the last good trailer, not verified |

## Verification
The bench drives full frames with extreme header values, such as chirp 511 and TX-max 1023, and with negative bins. A design with shifted field slices or the wrong bit order would show wrong values here. Headers with a bad preamble or a bad type are sent after a good frame. A parser that does not drop the window would give bins or pulses, and one that latches too early would corrupt the held fields. One window is cut short after a few bins, and one trailer has a bad postamble. Each must give an error pulse, never a done pulse, and leave the trailer fields alone. A partial word followed by a new window checks that raising the select clears the bit counter, since a design that kept the count would misalign the whole next frame.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
  localparam logic [7:0] HDR_PREAMBLE = 8'hAA;
  localparam logic [3:0] HDR_TYPE_RNG = 4'b0011;
  localparam logic [7:0] TRL_POSTAMB  = 8'h55;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY,
    ST_TRL,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/rfr_sync.sv
module rfr_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rfr_word_asm.sv
module rfr_word_asm #(
  parameter int WORD_W = 32,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              csn_s,
  output logic              word_vld,
  output logic [WORD_W-1:0] word,
  output logic              cs_start,
  output logic              cs_end
);
  logic              sclk_q, csn_q;
  logic [WORD_W-2:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              rise;

  assign rise = sclk_s & ~sclk_q & ~csn_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      csn_q    <= 1'b1;
      shreg    <= '0;
      bit_cnt  <= '0;
      word_vld <= 1'b0;
      word     <= '0;
      cs_start <= 1'b0;
      cs_end   <= 1'b0;
    end else begin
      sclk_q   <= sclk_s;
      csn_q    <= csn_s;
      cs_start <= csn_q & ~csn_s;
      cs_end   <= ~csn_q & csn_s;
      word_vld <= 1'b0;
      if (csn_s) begin
        bit_cnt <= '0;
      end else if (rise) begin
        shreg <= {shreg[WORD_W-3:0], mosi_s};
        if (bit_cnt == CNT_W'(WORD_W-1)) begin
          bit_cnt  <= '0;
          word     <= {shreg, mosi_s};
          word_vld <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rfr_parser.sv
module rfr_parser
  import rfr_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int NUM_BINS = 16,
  localparam int HALF_W  = WORD_W/2,
  localparam int BIN_W   = $clog2(NUM_BINS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     word_vld,
  input  logic [WORD_W-1:0]        word,
  input  logic                     cs_start,
  input  logic                     cs_end,
  output logic                     bin_valid,
  output logic [BIN_W-1:0]         bin_idx,
  output logic signed [HALF_W-1:0] bin_i,
  output logic signed [HALF_W-1:0] bin_q,
  output logic                     frame_done,
  output logic                     frame_error,
  output logic [8:0]               chirp_idx,
  output logic [9:0]               txmax_cfg,
  output logic [3:0]               frame_num,
  output logic [1:0]               cfg_msg,
  output logic [15:0]              checksum
);
  rx_state_e        state;
  logic [BIN_W-1:0] bin_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      bin_cnt     <= '0;
      bin_valid   <= 1'b0;
      bin_idx     <= '0;
      bin_i       <= '0;
      bin_q       <= '0;
      frame_done  <= 1'b0;
      frame_error <= 1'b0;
      chirp_idx   <= '0;
      txmax_cfg   <= '0;
      frame_num   <= '0;
      cfg_msg     <= '0;
      checksum    <= '0;
    end else begin
      bin_valid   <= 1'b0;
      frame_done  <= 1'b0;
      frame_error <= 1'b0;
      if (cs_end) begin
        if (state == ST_PAY || state == ST_TRL) frame_error <= 1'b1;
        state <= ST_IDLE;
      end else if (cs_start) begin
        state <= ST_HDR;
      end else if (word_vld) begin
        unique case (state)
          ST_HDR: begin
            if (word[31:24] == HDR_PREAMBLE && word[23:20] == HDR_TYPE_RNG) begin
              chirp_idx <= word[19:11];
              txmax_cfg <= word[9:0];
              bin_cnt   <= '0;
              state     <= ST_PAY;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_PAY: begin
            bin_valid <= 1'b1;
            bin_idx   <= bin_cnt;
            bin_i     <= word[WORD_W-1:HALF_W];
            bin_q     <= word[HALF_W-1:0];
            bin_cnt   <= bin_cnt + 1'b1;
            if (bin_cnt == BIN_W'(NUM_BINS-1)) state <= ST_TRL;
          end
          ST_TRL: begin
            if (word[7:0] == TRL_POSTAMB) begin
              frame_done <= 1'b1;
              checksum   <= word[31:16];
              frame_num  <= word[15:12];
              cfg_msg    <= word[9:8];
            end else begin
              frame_error <= 1'b1;
            end
            state <= ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/radar_frame_rx.sv
module radar_frame_rx #(
  parameter int WORD_W      = 32,
  parameter int NUM_BINS    = 16,
  parameter int SYNC_STAGES = 2,
  localparam int HALF_W     = WORD_W/2,
  localparam int BIN_W      = $clog2(NUM_BINS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     spi_sclk,
  input  logic                     spi_mosi,
  input  logic                     spi_csn,
  output logic                     bin_valid,
  output logic [BIN_W-1:0]         bin_idx,
  output logic signed [HALF_W-1:0] bin_i,
  output logic signed [HALF_W-1:0] bin_q,
  output logic                     frame_done,
  output logic                     frame_error,
  output logic [8:0]               chirp_idx,
  output logic [9:0]               txmax_cfg,
  output logic [3:0]               frame_num,
  output logic [1:0]               cfg_msg,
  output logic [15:0]              checksum
);
  logic [2:0]        pins_s;
  logic              word_vld, cs_start, cs_end;
  logic [WORD_W-1:0] word;

  rfr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_csn, spi_sclk, spi_mosi}),
    .q(pins_s)
  );

  rfr_word_asm #(.WORD_W(WORD_W)) u_asm (
    .clk(clk), .rst(rst),
    .sclk_s(pins_s[1]), .mosi_s(pins_s[0]), .csn_s(pins_s[2]),
    .word_vld(word_vld), .word(word),
    .cs_start(cs_start), .cs_end(cs_end)
  );

  rfr_parser #(.WORD_W(WORD_W), .NUM_BINS(NUM_BINS)) u_parse (
    .clk(clk), .rst(rst),
    .word_vld(word_vld), .word(word),
    .cs_start(cs_start), .cs_end(cs_end),
    .bin_valid(bin_valid), .bin_idx(bin_idx), .bin_i(bin_i), .bin_q(bin_q),
    .frame_done(frame_done), .frame_error(frame_error),
    .chirp_idx(chirp_idx), .txmax_cfg(txmax_cfg),
    .frame_num(frame_num), .cfg_msg(cfg_msg), .checksum(checksum)
  );
endmodule

// File: rtl/radar_frame_rx_chk.sv
module radar_frame_rx_chk #(
  parameter int BIN_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bin_valid,
  input logic [BIN_W-1:0] bin_idx,
  input logic             frame_done,
  input logic             frame_error,
  input logic [8:0]       chirp_idx,
  input logic [3:0]       frame_num
);
  p_done_err_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(frame_done && frame_error));
  p_done_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  p_err_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    frame_error |=> !frame_error);
  p_done_after_last_bin_r5: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (bin_idx == {BIN_W{1'b1}} && !bin_valid));
  p_fields_hold_r10: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> ($stable(chirp_idx) && $stable(frame_num)));
endmodule

bind radar_frame_rx radar_frame_rx_chk #(.BIN_W(BIN_W)) u_chk (
  .clk(clk), .rst(rst), .bin_valid(bin_valid), .bin_idx(bin_idx),
  .frame_done(frame_done), .frame_error(frame_error),
  .chirp_idx(chirp_idx), .frame_num(frame_num)
);

// File: tb/tb_radar_frame_rx.sv
module tb_radar_frame_rx;
  logic clk = 1'b0, rst = 1'b1;
  logic spi_sclk = 1'b0, spi_mosi = 1'b0, spi_csn = 1'b1;
  logic bin_valid, frame_done, frame_error;
  logic [3:0] bin_idx, frame_num;
  logic signed [15:0] bin_i, bin_q;
  logic [8:0] chirp_idx;
  logic [9:0] txmax_cfg;
  logic [1:0] cfg_msg;
  logic [15:0] checksum;

  int total = 0, bad = 0;
  int n_bins = 0, n_done = 0, n_err = 0;
  logic [3:0]  got_idx [16];
  logic [15:0] got_i [16], got_q [16];
  logic [31:0] pay [16];

  always #5 clk = ~clk;

  radar_frame_rx dut (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_csn(spi_csn),
    .bin_valid(bin_valid), .bin_idx(bin_idx), .bin_i(bin_i), .bin_q(bin_q),
    .frame_done(frame_done), .frame_error(frame_error),
    .chirp_idx(chirp_idx), .txmax_cfg(txmax_cfg),
    .frame_num(frame_num), .cfg_msg(cfg_msg), .checksum(checksum)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (bin_valid) begin
        if (n_bins < 16) begin
          got_idx[n_bins] = bin_idx;
          got_i[n_bins] = bin_i;
          got_q[n_bins] = bin_q;
        end
        n_bins++;
      end
      if (frame_done) n_done++;
      if (frame_error) n_err++;
    end
  end

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: run hung");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] w, input int nbits);
    for (int b = 31; b > 31 - nbits; b--) begin
      @(negedge clk); spi_mosi = w[b];
      repeat (5) @(negedge clk); spi_sclk = 1'b1;
      repeat (5) @(negedge clk); spi_sclk = 1'b0;
    end
  endtask

  task automatic cs_low();
    @(negedge clk); spi_csn = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (10) @(negedge clk); spi_csn = 1'b1;
    repeat (30) @(negedge clk);
  endtask

  task automatic clear_counts();
    n_bins = 0; n_done = 0; n_err = 0;
  endtask

  function automatic logic [31:0] mk_hdr(logic [7:0] pre, logic [3:0] typ,
                                        logic [8:0] ch, logic [9:0] tx);
    return {pre, typ, ch, 1'b1, tx};
  endfunction

  function automatic logic [31:0] mk_trl(logic [15:0] cs, logic [3:0] fn,
                                        logic [1:0] cm, logic [7:0] post);
    return {cs, fn, 2'b11, cm, post};
  endfunction

  task automatic fill_pay(input int seed);
    for (int k = 0; k < 16; k++)
      pay[k] = {16'(seed * 131 - k * 977), 16'(-seed - k * 4099)};
  endtask

  // Sends header, nb payload words, optional trailer.
  task automatic send_frame(input logic [31:0] hdr, input int nb,
                            input bit with_trl, input logic [31:0] trl);
    cs_low();
    send_bits(hdr, 32);
    for (int k = 0; k < nb; k++) send_bits(pay[k], 32);
    if (with_trl) send_bits(trl, 32);
    cs_high();
  endtask

  task automatic check_bins(input string req);
    chk(req, 32'(n_bins), 32'd16);
    for (int k = 0; k < 16; k++) begin
      chk(req, 32'(got_idx[k]), 32'(k));
      chk(req, {got_i[k], got_q[k]}, pay[k]);
    end
  endtask

  task automatic t_reset();
    chk("R1 bin_valid", 32'(bin_valid), 0);
    chk("R1 done/err", {frame_done, frame_error}, 0);
    chk("R1 fields", {chirp_idx, txmax_cfg, frame_num, cfg_msg}, 0);
    chk("R1 checksum/bins", {checksum, bin_i}, 0);
  endtask

  task automatic t_good(input int seed, input logic [8:0] ch, input logic [9:0] tx,
                        input logic [15:0] cs, input logic [3:0] fn, input logic [1:0] cm);
    clear_counts();
    fill_pay(seed);
    send_frame(mk_hdr(8'hAA, 4'b0011, ch, tx), 16, 1'b1, mk_trl(cs, fn, cm, 8'h55));
    check_bins("R5/R2 bins");
    chk("R6 done count", 32'(n_done), 1);
    chk("R6 no error", 32'(n_err), 0);
    chk("R3 chirp", 32'(chirp_idx), 32'(ch));
    chk("R3 txmax", 32'(txmax_cfg), 32'(tx));
    chk("R6 frame_num/cfg", {frame_num, cfg_msg}, {fn, cm});
    chk("R11 checksum", 32'(checksum), 32'(cs));
  endtask

  task automatic t_bad_header(input logic [7:0] pre, input logic [3:0] typ);
    logic [31:0] keep;
    keep = {chirp_idx, txmax_cfg, frame_num, cfg_msg, checksum[6:0]};
    clear_counts();
    fill_pay(9);
    send_frame(mk_hdr(pre, typ, 9'h0AB, 10'h155), 16, 1'b1, mk_trl(16'h1234, 4'h9, 2'b10, 8'h55));
    chk("R4 no bins", 32'(n_bins), 0);
    chk("R4 no pulses", 32'(n_done + n_err), 0);
    chk("R10 fields kept", {chirp_idx, txmax_cfg, frame_num, cfg_msg, checksum[6:0]}, keep);
  endtask

  task automatic t_bad_post();
    logic [31:0] keep;
    keep = {8'h0, frame_num, cfg_msg, checksum};
    clear_counts();
    fill_pay(5);
    send_frame(mk_hdr(8'hAA, 4'b0011, 9'h033, 10'h0F0), 16, 1'b1, mk_trl(16'hBEEF, 4'h6, 2'b01, 8'h54));
    chk("R7 error pulse", 32'(n_err), 1);
    chk("R7 no done", 32'(n_done), 0);
    chk("R7 trailer kept", {8'h0, frame_num, cfg_msg, checksum}, keep);
    chk("R10 header updated", 32'(chirp_idx), 32'h033);
  endtask

  task automatic t_early_cs();
    clear_counts();
    fill_pay(3);
    send_frame(mk_hdr(8'hAA, 4'b0011, 9'h011, 10'h022), 5, 1'b0, 32'h0);
    chk("R8 bins before cut", 32'(n_bins), 5);
    chk("R8 error pulse", 32'(n_err), 1);
    chk("R8 no done", 32'(n_done), 0);
  endtask

  task automatic t_partial();
    clear_counts();
    cs_low();
    send_bits(32'hAA3F_FFFF, 13);
    cs_high();
    chk("R9 partial silent", 32'(n_bins + n_done + n_err), 0);
    t_good(21, 9'h155, 10'h2AA, 16'h0000, 4'h1, 2'b00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_good(1, 9'h000, 10'h011, 16'hECEE, 4'h1, 2'b00);
    t_good(7, 9'h1FF, 10'h3FF, 16'hFFFF, 4'hF, 2'b11);
    t_bad_header(8'hAB, 4'b0011);
    t_bad_header(8'hAA, 4'b0100);
    t_bad_post();
    t_early_cs();
    t_partial();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule